// File: doc/BRIEF.md
# Prioritized Interrupt Vector Register

This block sits beside a serial-bus controller and collects seven kinds of controller event into sticky flags. A per-source enable mask decides which of these flags may take part. The CPU reads a single vector register that reports the most urgent enabled flag as a 3-bit code. The same read retires that one flag.

Each event input is a one-cycle set pulse. A flag stays pending until the read that reports it. The interrupt request output is a one-cycle pulse. It fires when the block goes from having nothing to report to having something to report. It fires again one cycle after a clearing read if more enabled work is still pending, so the CPU can take one interrupt per event.

The read port is a plain strobe with address and data. It has no handshake and no back-pressure: a read completes in the cycle its strobe is high. The read data is combinational in that cycle, and the flag clear lands on the next clock edge. There is no write path, so writes cannot change the register. The event and mask pins are plain control inputs.

Top module: `irq_vector_reg`

## Requirements
- R1: Read data is 32 bits wide. The code sits in bits [2:0], and bits [31:3] always read as zero.
- R2: After reset every flag is clear, a vector read returns 0 and `irq_o` is low.
- R3: Event input bit i (i = 0..6) maps to code i+1. The codes are:
  - 1: arbitration lost
  - 2: no-acknowledge
  - 3: access ready
  - 4: receive ready
  - 5: transmit ready
  - 6: stop seen
  - 7: addressed as slave
  - 0: nothing pending
- R4: When several enabled flags are pending, the smallest nonzero code is reported.
- R5: A vector read clears, on the next clock edge, only the flag whose code it returned. All other flags keep their state.
- R6: `irq_o` pulses for one cycle in the first cycle in which an enabled flag is pending after a cycle with none pending.
- R7: `irq_o` pulses in the cycle after a clearing read when at least one enabled flag is still pending.
- R8: A flag whose mask bit is 0 still latches its event. It is ignored for code selection and for `irq_o` until its mask bit is set again.
- R9: If a set pulse and a clearing read hit the same flag in one cycle, the flag stays pending.
- R10: The vector register sits at address 0x0A. A read at any other address returns zero and changes no flag.
- R11: Read data reflects the current flags and mask in the same cycle as the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set_i | input | 7 | One-cycle set pulses; bit i sets the flag for code i+1 |
| en_mask_i | input | 7 | Per-source enable, same bit order as evt_set_i |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 6 | Read address |
| rd_data_o | output | 32 | Read data, combinational while rd_en_i is high |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions assume that the event inputs and the read strobe are synchronous to the clock and stable around the rising edge. They also assume that a set pulse, not a level, is the only way a flag rises. The bench drives all inputs at the falling edge. It keeps event traffic sparse enough that flags are both set and drained, mixing vector-address and stray-address reads. It changes the mask only occasionally, so that both masked latching and unmasking are reached.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned SRC_N  = 7;
  localparam int unsigned CODE_W = $clog2(SRC_N + 1);
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
  parameter int unsigned SRC_N = irqv_pkg::SRC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set_i,
  input  logic [SRC_N-1:0] clr_i,
  output logic [SRC_N-1:0] flags_o
);
  logic [SRC_N-1:0] flags_q;

  for (genvar g = 0; g < SRC_N; g++) begin : g_flag
    // set has priority over a clearing read on the same bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[g] <= 1'b0;
      else if (set_i[g]) flags_q[g] <= 1'b1;
      else if (clr_i[g]) flags_q[g] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_q[g]); // R9

    AST_HOLD_UNLESS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[g] && !clr_i[g]) |=> flags_q[g]); // R5
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
  parameter int unsigned SRC_N  = irqv_pkg::SRC_N,
  parameter int unsigned CODE_W = irqv_pkg::CODE_W
) (
  input  logic [SRC_N-1:0]  act_i,
  output logic [CODE_W-1:0] code_o,
  output logic [SRC_N-1:0]  win_oh_o
);
  // scan from the lowest-priority bit up so the lowest index wins
  always_comb begin
    code_o   = '0;
    win_oh_o = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        code_o      = CODE_W'(i + 1);
        win_oh_o    = '0;
        win_oh_o[i] = 1'b1;
      end
    end
  end

  always_comb begin
    AST_WIN_ONEHOT: assert ($onehot0(win_oh_o)); // R4
  end
endmodule

// File: rtl/irqv_req_gen.sv
module irqv_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic any_i,
  input  logic clr_rd_i,
  output logic irq_o
);
  logic any_prev_q;
  logic clr_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_prev_q <= 1'b0;
      clr_done_q <= 1'b0;
    end else begin
      any_prev_q <= any_i;
      clr_done_q <= clr_rd_i;
    end
  end

  assign irq_o = any_i && (!any_prev_q || clr_done_q);

  AST_FIRST_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !any_i |=> (!any_i || irq_o)); // R6

  AST_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd_i |=> (!any_i || irq_o)); // R7
endmodule

// File: rtl/irq_vector_reg.sv
module irq_vector_reg #(
  parameter int unsigned          ADDR_W   = 6,
  parameter logic [ADDR_W-1:0]    VEC_ADDR = 6'h0A,
  parameter int unsigned          DATA_W   = 32,
  parameter int unsigned          SRC_N    = irqv_pkg::SRC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  evt_set_i,
  input  logic [SRC_N-1:0]  en_mask_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned CODE_W = $clog2(SRC_N + 1);

  logic [SRC_N-1:0]  flags;
  logic [SRC_N-1:0]  active;
  logic [SRC_N-1:0]  win_oh;
  logic [SRC_N-1:0]  clr_vec;
  logic [CODE_W-1:0] code;
  logic              hit;
  logic              clr_rd;

  assign hit     = rd_en_i && (rd_addr_i == VEC_ADDR);
  assign active  = flags & en_mask_i;
  assign clr_vec = hit ? win_oh : '0;
  assign clr_rd  = hit && (code != '0);

  irqv_flag_bank #(.SRC_N(SRC_N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (evt_set_i),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  irqv_prio_enc #(.SRC_N(SRC_N), .CODE_W(CODE_W)) u_prio (
    .act_i    (active),
    .code_o   (code),
    .win_oh_o (win_oh)
  );

  irqv_req_gen u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_i    (|active),
    .clr_rd_i (clr_rd),
    .irq_o    (irq_o)
  );

  assign rd_data_o = hit ? DATA_W'(code) : '0;

  AST_STRAY_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !hit && (evt_set_i == '0)) |=> $stable(flags)); // R10

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> !irq_o); // R8
endmodule

// File: tb/irq_vector_reg_bench.sv
module irq_vector_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] VEC = 6'h0A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt_set_i = '0;
  logic [6:0]  en_mask_i = '1;
  logic        rd_en_i = 1'b0;
  logic [5:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [6:0] m_flags = '0;
  logic       m_prev = 1'b0;
  logic       m_clrd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_reg u_irq_vector_reg (
    .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set_i), .en_mask_i(en_mask_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  function automatic logic [2:0] f_code(logic [6:0] fl, logic [6:0] mk);
    logic [2:0] c = 3'd0;
    for (int i = 6; i >= 0; i--) if (fl[i] && mk[i]) c = 3'(i + 1);
    return c;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, check outputs, advance model at posedge
  task automatic step(logic [6:0] evt, logic [6:0] msk, logic rd,
                      logic [5:0] addr, string tag);
    logic [2:0]  c;
    logic        any_e, hit, exp_irq;
    logic [31:0] exp_d;
    logic [6:0]  nxt;
    @(negedge clk);
    evt_set_i = evt; en_mask_i = msk; rd_en_i = rd; rd_addr_i = addr;
    #1;
    c       = f_code(m_flags, msk);
    any_e   = |(m_flags & msk);
    hit     = rd && (addr == VEC);
    exp_d   = hit ? {29'd0, c} : 32'd0;
    exp_irq = any_e && (!m_prev || m_clrd);
    chk({tag, " data"}, rd_data_o, exp_d);
    chk({tag, " irq"}, {31'd0, irq_o}, {31'd0, exp_irq});
    nxt = m_flags;
    if (hit && c != 0) nxt[c-1] = 1'b0;
    nxt = nxt | evt;
    @(posedge clk);
    m_prev  = any_e;
    m_clrd  = hit && (c != 0);
    m_flags = nxt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R2 reset state
    step(7'h00, 7'h7F, 1'b1, VEC, "R2");
    step(7'h00, 7'h7F, 1'b0, VEC, "R2");
    // R3 each source alone: set, irq (R6), read reports i+1 (R11, R1)
    for (int i = 0; i < 7; i++) begin
      step(7'(1 << i), 7'h7F, 1'b0, VEC, "R3");
      step(7'h00, 7'h7F, 1'b0, VEC, "R6");
      step(7'h00, 7'h7F, 1'b1, VEC, "R3");
      step(7'h00, 7'h7F, 1'b0, VEC, "R5");
    end
    // R4 / R5 / R7 several pending, drained in priority order
    step(7'b1001010, 7'h7F, 1'b0, VEC, "R4");
    step(7'h00, 7'h7F, 1'b1, VEC, "R4");
    step(7'h00, 7'h7F, 1'b0, VEC, "R7");
    step(7'h00, 7'h7F, 1'b1, VEC, "R5");
    step(7'h00, 7'h7F, 1'b1, VEC, "R7");
    step(7'h00, 7'h7F, 1'b1, VEC, "R5");
    step(7'h00, 7'h7F, 1'b0, VEC, "R5");
    // R8 masked source latches silently, then appears
    step(7'b0000001, 7'h7E, 1'b0, VEC, "R8");
    step(7'h00, 7'h7E, 1'b1, VEC, "R8");
    step(7'b0010000, 7'h7E, 1'b0, VEC, "R8");
    step(7'h00, 7'h7E, 1'b1, VEC, "R8");
    step(7'h00, 7'h7F, 1'b1, VEC, "R8");
    step(7'h00, 7'h7F, 1'b1, VEC, "R8");
    step(7'h00, 7'h7F, 1'b1, VEC, "R8");
    // R9 set and clear on the same flag
    step(7'b0000100, 7'h7F, 1'b0, VEC, "R9");
    step(7'b0000100, 7'h7F, 1'b1, VEC, "R9");
    step(7'h00, 7'h7F, 1'b1, VEC, "R9");
    step(7'h00, 7'h7F, 1'b1, VEC, "R9");
    // R10 stray address reads leave flags alone
    step(7'b0100000, 7'h7F, 1'b0, VEC, "R10");
    step(7'h00, 7'h7F, 1'b1, 6'h0B, "R10");
    step(7'h00, 7'h7F, 1'b1, 6'h00, "R10");
    step(7'h00, 7'h7F, 1'b1, VEC, "R10");
    step(7'h00, 7'h7F, 1'b1, VEC, "R10");
    // random traffic
    begin
      logic [6:0] msk = 7'h7F;
      for (int k = 0; k < 3000; k++) begin
        logic [6:0] ev;
        logic [5:0] ad;
        ev = (($urandom % 4) == 0) ? 7'($urandom) & 7'($urandom) : 7'h00;
        ad = (($urandom % 5) == 0) ? 6'($urandom) : VEC;
        if (($urandom % 50) == 0) msk = 7'($urandom);
        step(ev, msk, ($urandom % 3) == 0, ad, "R4 R5 R7 R8");
      end
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1;
    $finish;
  end
endmodule